// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit evaluates a conditional select in a single stage. It returns the first operand when the condition bit is set. Otherwise it returns the second operand after one of four transforms: pass, increment, bitwise invert or two's-complement negate. The same unit also performs two conditional-zero moves. Each of these yields the first operand or zero, depending on whether the second operand is zero.

The caller supplies the condition as a single bit, and supplies any zero register as a literal zero operand. This lets one operation class produce several useful results. Zero operands with the increment transform give a 0/1 flag. Zero operands with the invert transform give a 0/all-ones mask. Equal operands with the negate transform, under a "non-negative" condition, give an absolute value.

The result is captured in an output register while the input strobe is high, and a valid flag follows one cycle later. Arithmetic wraps modulo 2^XLEN.

Top module: `csel_unit`

## Requirements
- R1: For op codes 0 to 3 (op_i = 3'b000..3'b011), when cond_i is 1 the result is rs1_i.
- R2: Op 0 (pass) with cond_i = 0 yields rs2_i.
- R3: Op 1 (increment) with cond_i = 0 yields rs2_i + 1 modulo 2^XLEN, so all-ones wraps to zero.
- R4: Op 2 (invert) with cond_i = 0 yields the bitwise NOT of rs2_i.
- R5: Op 3 (negate) with cond_i = 0 yields ~rs2_i + 1 modulo 2^XLEN, so the most negative value negates to itself.
- R6: With rs1_i = rs2_i = 0, op 1 yields 0 when cond_i = 1 and 1 when cond_i = 0. Op 2 yields 0 when cond_i = 1 and all ones when cond_i = 0.
- R7: Op 4 yields 0 when rs2_i is zero and rs1_i otherwise; cond_i is ignored.
- R8: Op 5 yields 0 when rs2_i is non-zero and rs1_i otherwise; cond_i is ignored.
- R9: Op codes 6 and 7 yield zero.
- R10: result_o changes only on a clock edge where valid_i is 1, and it otherwise holds its value.
- R11: valid_o equals valid_i from the previous clock edge. While rst_ni is low, valid_o and result_o are 0.
- R12: Op 3 with rs1_i = rs2_i = x and cond_i = 1 exactly when x is non-negative yields |x| modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe; a high value loads the result register |
| op_i | input | 3 | Operation select (0..3 select transform, 4/5 conditional zero) |
| cond_i | input | 1 | Condition bit for ops 0..3 |
| rs1_i | input | XLEN | Operand returned when the condition holds |
| rs2_i | input | XLEN | Transformed operand, or the zero test operand for ops 4/5 |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | XLEN | Registered result |

## Verification
Apart from the valid flag, the only state is the result register. A wrong transform or a wrong decode therefore appears on result_o at the first edge that loads an affected operation. A wrong hold appears on the first idle cycle that follows with changed inputs. The bench sweeps every op, condition and operand pair at a 4-bit width, so a fault in the shared incrementer or the invert stage shows up within one sweep of a single op. A stuck or misaligned valid flag shows up on the cycle after the first idle input.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [2:0] {
    OP_PASS  = 3'd0,
    OP_INC   = 3'd1,
    OP_INV   = 3'd2,
    OP_NEG   = 3'd3,
    OP_ZEQZ  = 3'd4,
    OP_ZNEZ  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } csel_op_e;
endpackage

// File: rtl/csel_xform.sv
// f(x): optional invert, then optional +1; negate is both
module csel_xform #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] operand_i,
  input  logic            inv_i,
  input  logic            inc_i,
  output logic [XLEN-1:0] result_o
);
  logic [XLEN-1:0] inv_val;
  logic [XLEN-1:0] inc_val;

  assign inv_val  = inv_i ? ~operand_i : operand_i;
  assign inc_val  = {{(XLEN-1){1'b0}}, inc_i};
  assign result_o = inv_val + inc_val;
endmodule

// File: rtl/csel_czero.sv
module csel_czero #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic            zero_on_nz_i,
  output logic [XLEN-1:0] result_o
);
  logic rs2_is_zero;
  logic kill;

  assign rs2_is_zero = (rs2_i == '0);
  assign kill        = zero_on_nz_i ? !rs2_is_zero : rs2_is_zero;
  assign result_o    = kill ? '0 : rs1_i;
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic            cond_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o
);
  csel_op_e        op;
  logic [XLEN-1:0] xform_res;
  logic [XLEN-1:0] czero_res;
  logic [XLEN-1:0] next_res;
  logic            res_q_en;

  assign op       = csel_op_e'(op_i);
  assign res_q_en = valid_i;

  csel_xform #(.XLEN(XLEN)) u_xform (
    .operand_i (rs2_i),
    .inv_i     (op_i[1]),
    .inc_i     (op_i[0]),
    .result_o  (xform_res)
  );

  csel_czero #(.XLEN(XLEN)) u_czero (
    .rs1_i        (rs1_i),
    .rs2_i        (rs2_i),
    .zero_on_nz_i (op_i[0]),
    .result_o     (czero_res)
  );

  always_comb begin
    unique case (op)
      OP_PASS, OP_INC, OP_INV, OP_NEG: next_res = cond_i ? rs1_i : xform_res;
      OP_ZEQZ, OP_ZNEZ:                next_res = czero_res;
      default:                         next_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (res_q_en) result_o <= next_res;
    end
  end
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [2:0]      op_i,
  input logic            cond_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o
);
  p_taken_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i < 3'd4 && cond_i) |=> result_o == $past(rs1_i));

  p_negate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && !cond_i) |=> result_o == -$past(rs2_i));

  p_zero_eqz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && rs2_i == '0) |=> result_o == '0);

  p_zero_nez_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd5 && rs2_i != '0) |=> result_o == '0);

  p_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd5) |=> result_o == '0);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  p_valid_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

bind csel_unit csel_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_csel_unit.sv
module sim_csel_unit;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic         cond_i = 1'b0;
  logic [W-1:0] rs1_i = '0;
  logic [W-1:0] rs2_i = '0;
  logic         valid_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  csel_unit #(.XLEN(W)) u0 (.*);

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (op=%0d cond=%0d a=%0d b=%0d)",
               tag, got, exp, op_i, cond_i, rs1_i, rs2_i);
    end
  endtask

  function automatic int model(int op, int c, int a, int b);
    case (op)
      0: return c ? a : b;
      1: return c ? a : ((b + 1) & M);
      2: return c ? a : (M - b);
      3: return c ? a : ((M + 1 - b) & M);
      4: return (b == 0) ? 0 : a;
      5: return (b != 0) ? 0 : a;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int op, int c);
    if (c && op < 4) return "R1";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(int op, int c, int a, int b);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'(op); cond_i = c[0];
    rs1_i = W'(a); rs2_i = W'(b);
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    #2;
    check("R11 reset valid", int'(valid_o), 0);
    check("R11 reset result", int'(result_o), 0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // full sweep
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a <= M; a++)
          for (int b = 0; b <= M; b++) begin
            apply(op, c, a, b);
            check(tag_of(op, c), int'(result_o), model(op, c, a, b));
            check("R11 valid", int'(valid_o), 1);
          end

    // negate equals increment of inverted value
    for (int b = 0; b <= M; b++) begin
      int inv_r;
      apply(2, 0, 0, b);
      inv_r = int'(result_o);
      apply(3, 0, 0, b);
      check("R5 neg=inc(not)", int'(result_o), (inv_r + 1) & M);
    end
    apply(3, 0, 5, 8);
    check("R5 most negative", int'(result_o), 8);

    // boolean and mask
    apply(1, 1, 0, 0); check("R6 bool true", int'(result_o), 0);
    apply(1, 0, 0, 0); check("R6 bool false", int'(result_o), 1);
    apply(2, 1, 0, 0); check("R6 mask true", int'(result_o), 0);
    apply(2, 0, 0, 0); check("R6 mask false", int'(result_o), M);

    // absolute value
    for (int x = 0; x <= M; x++) begin
      int mag;
      mag = (x < 8) ? x : ((16 - x) & M);
      apply(3, (x < 8) ? 1 : 0, x, x);
      check("R12 abs", int'(result_o), mag);
    end

    // hold when idle
    apply(0, 1, 9, 3);
    check("R10 load", int'(result_o), 9);
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 3'd0; cond_i = 1'b1; rs1_i = 4'd6;
    @(posedge clk_i); #2;
    check("R10 hold", int'(result_o), 9);
    check("R11 valid drop", int'(valid_o), 0);
    @(negedge clk_i);
    rs1_i = 4'd2; op_i = 3'd4; rs2_i = 4'd1;
    @(posedge clk_i); #2;
    check("R10 hold2", int'(result_o), 9);
    check("R11 valid low", int'(valid_o), 0);

    // reset mid-run
    apply(0, 1, 7, 0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R11 async reset result", int'(result_o), 0);
    check("R11 async reset valid", int'(valid_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule